// File: doc/BRIEF.md
# Line-Locked Feedback Pixel Divider

This block divides a pixel clock by a programmable ratio and closes a line-locked clock loop. Once per line it produces a feedback pulse. The falling edge of that pulse is the timing event that an external phase and frequency detector aligns with the rising edge of the line-rate reference. So the loop multiplies the line rate by the ratio, typically about 1000. The same counter also supplies a horizontal pixel index that a frame store uses to address its memory.

The ratio input is 11 bits wide. It is sampled only when a line ends, so changing it never shortens or stretches the line in progress. Ratios below 32 are raised to 32, which leaves room for the high part of the pulse.

The feedback pulse is high for exactly 16 counted clocks before it falls. This meets the minimum feedback width that the detector needs.

An optional halving stage sits in front of the counter. When it is enabled, the counter advances on every second clock, using a 50% duty enable, so every count spans two clocks.

Top module: `line_pixel_divider`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, the pixel count is 0 and the feedback output is low.
- R2: The pixel count rises by one on each counted clock, from 0 up to N-1, then returns to 0. It never reaches N.
- R3: The feedback output falls in the same clock edge in which the pixel count returns to 0. Exactly one fall occurs per line, so consecutive falls are N counted clocks apart.
- R4: The feedback output rises in the edge where the pixel count becomes N-16. It stays high for exactly 16 counted clocks.
- R5: A new value on the ratio input takes effect only at the next return of the count to 0. The line in progress keeps the ratio that was loaded when it began.
- R6: A ratio input below 32, including 0, behaves as a ratio of 32.
- R7: When the halving enable is high, the counter advances on every second clock. A line then lasts 2N clocks and the feedback pulse is high for 32 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_in | input | 11 | Requested division ratio N |
| halve_en | input | 1 | High: count on every second clock |
| fb_pulse | output | 1 | Feedback pulse; its falling edge ends the line |
| pix_count | output | 11 | Horizontal pixel index within the line |

## Verification
The divider is run at a nominal ratio of 1000, at a small ratio of 40 and at exactly 32. These runs separate a correct period from off-by-one errors in the wrap and in the pulse start.

Ratios of 5 and 0 must give the same 32-clock line as a ratio of 32, which shows that the floor applies.

In another run the ratio is changed in the middle of a line. The line in progress must keep its old length and the following line must take the new one, which exposes any load that happens before the line ends.

With halving enabled, the line and the pulse must each take twice as many clocks while the pixel index still ends at N-1.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  localparam int CNT_W   = 11;
  localparam int HI_LEN  = 16;
  localparam int MIN_N   = 32;

  function automatic logic [CNT_W-1:0] floor_ratio(input logic [CNT_W-1:0] req);
    if (req < CNT_W'(MIN_N)) floor_ratio = CNT_W'(MIN_N);
    else                     floor_ratio = req;
  endfunction
endpackage

// File: rtl/lpd_halver.sv
module lpd_halver (
  input  logic clk,
  input  logic rst,
  input  logic halve_en,
  output logic tick
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst)           phase_q <= 1'b0;
    else if (halve_en) phase_q <= ~phase_q;
    else               phase_q <= 1'b0;
  end

  assign tick = halve_en ? phase_q : 1'b1;
endmodule

// File: rtl/lpd_ratio_latch.sv
module lpd_ratio_latch #(
  parameter int CNT_W = lpd_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic [CNT_W-1:0] ratio_in,
  output logic [CNT_W-1:0] n_active
);
  always_ff @(posedge clk) begin
    if (rst || wrap) n_active <= lpd_pkg::floor_ratio(ratio_in);
  end
endmodule

// File: rtl/lpd_line_counter.sv
module lpd_line_counter #(
  parameter int CNT_W  = lpd_pkg::CNT_W,
  parameter int HI_LEN = lpd_pkg::HI_LEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] n_active,
  output logic             wrap,
  output logic [CNT_W-1:0] count,
  output logic             fb
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI_LEN);

  logic [CNT_W-1:0] next_count;
  logic             at_end;

  assign at_end     = (count == n_active - ONE);
  assign wrap       = tick && at_end;
  assign next_count = count + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      fb    <= 1'b0;
    end else if (tick) begin
      if (at_end) begin
        count <= '0;
        fb    <= 1'b0;
      end else begin
        count <= next_count;
        if (next_count == n_active - HI_C) fb <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/line_pixel_divider.sv
module line_pixel_divider #(
  parameter int CNT_W  = lpd_pkg::CNT_W,
  parameter int HI_LEN = lpd_pkg::HI_LEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] ratio_in,
  input  logic             halve_en,
  output logic             fb_pulse,
  output logic [CNT_W-1:0] pix_count
);
  logic             cnt_tick;
  logic             line_wrap;
  logic [CNT_W-1:0] n_active;

  lpd_halver u_halver (
    .clk      (clk),
    .rst      (rst),
    .halve_en (halve_en),
    .tick     (cnt_tick)
  );

  lpd_ratio_latch #(.CNT_W(CNT_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .wrap     (line_wrap),
    .ratio_in (ratio_in),
    .n_active (n_active)
  );

  lpd_line_counter #(.CNT_W(CNT_W), .HI_LEN(HI_LEN)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .tick     (cnt_tick),
    .n_active (n_active),
    .wrap     (line_wrap),
    .count    (pix_count),
    .fb       (fb_pulse)
  );
endmodule

// File: rtl/lpd_checker.sv
module lpd_checker #(
  parameter int CNT_W  = lpd_pkg::CNT_W,
  parameter int HI_LEN = lpd_pkg::HI_LEN,
  parameter int MIN_N  = lpd_pkg::MIN_N
) (
  input logic             clk,
  input logic             rst,
  input logic             fb_pulse,
  input logic [CNT_W-1:0] pix_count,
  input logic [CNT_W-1:0] n_act,
  input logic             tick,
  input logic             halve_en
);
  logic [CNT_W:0] hi_cyc;

  always_ff @(posedge clk) begin
    if (rst || !fb_pulse) hi_cyc <= '0;
    else                  hi_cyc <= hi_cyc + 1'b1;
  end

  p_bound_r2: assert property (@(posedge clk) disable iff (rst)
    pix_count < n_act);

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (pix_count != $past(pix_count)) |-> (pix_count == $past(pix_count) + 1'b1 || pix_count == '0));

  p_fall_at_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(fb_pulse) |-> pix_count == '0);

  p_min_high_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(fb_pulse) |-> hi_cyc >= (CNT_W+1)'(HI_LEN));

  p_load_at_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(n_act) |-> pix_count == '0);

  p_floor_r6: assert property (@(posedge clk) disable iff (rst)
    n_act >= CNT_W'(MIN_N));

  p_halve_r7: assert property (@(posedge clk) disable iff (rst)
    (halve_en && tick) |=> (!halve_en || !tick));
endmodule

bind line_pixel_divider lpd_checker #(.CNT_W(CNT_W), .HI_LEN(HI_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fb_pulse  (fb_pulse),
  .pix_count (pix_count),
  .n_act     (n_active),
  .tick      (cnt_tick),
  .halve_en  (halve_en)
);

// File: tb/line_pixel_divider_bench.sv
module line_pixel_divider_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [10:0] ratio_in;
  logic        halve_en;
  logic        fb_pulse;
  logic [10:0] pix_count;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  line_pixel_divider u_line_pixel_divider (
    .clk(clk), .rst(rst), .ratio_in(ratio_in), .halve_en(halve_en),
    .fb_pulse(fb_pulse), .pix_count(pix_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fall();
    logic p;
    p = fb_pulse;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (p && !fb_pulse) return;
      p = fb_pulse;
    end
    check(1'b0, "R3 timeout waiting for fall", 0, 1);
  endtask

  // Called right after a fall: measures the line up to the next fall.
  task automatic measure(output int per, output int hi, output int pix_rise,
                         output int pix_max, output int step_err, output int fall_pix);
    logic        p;
    logic [10:0] last;
    per = 0; hi = 0; pix_rise = -1; pix_max = 0; step_err = 0; fall_pix = -1;
    p = fb_pulse;
    last = pix_count;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      per++;
      if (fb_pulse) hi++;
      if (fb_pulse && !p) pix_rise = pix_count;
      if (int'(pix_count) > pix_max) pix_max = pix_count;
      if (pix_count != last && pix_count != last + 11'd1 && pix_count != 11'd0) step_err++;
      last = pix_count;
      if (!fb_pulse && p) begin
        fall_pix = pix_count;
        return;
      end
      p = fb_pulse;
    end
    check(1'b0, "R3 timeout while measuring", per, 0);
  endtask

  task automatic line_ok(input int n, input int mult, input string tag);
    int per, hi, pr, pm, se, fp;
    measure(per, hi, pr, pm, se, fp);
    check(per == n*mult, {tag, " R3 line period"}, per, n*mult);
    check(hi == 16*mult, {tag, " R4 high width"}, hi, 16*mult);
    check(pr == n-16, {tag, " R4 count at rise"}, pr, n-16);
    check(fp == 0, {tag, " R3 count at fall"}, fp, 0);
    check(pm == n-1 && se == 0, {tag, " R2 count range and steps"}, pm, n-1);
  endtask

  task automatic t_reset();
    rst = 1'b1; ratio_in = 11'd1000; halve_en = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(pix_count == 0, "R1 count in reset", pix_count, 0);
    check(fb_pulse == 1'b0, "R1 fb in reset", fb_pulse, 0);
    rst = 1'b0;
    @(negedge clk);
    check(pix_count == 0 || pix_count == 1, "R1 count after release", pix_count, 1);
    check(fb_pulse == 1'b0, "R1 fb after release", fb_pulse, 0);
  endtask

  task automatic t_ratio(input int req, input int eff, input string tag);
    ratio_in = 11'(req);
    wait_fall();
    wait_fall();
    line_ok(eff, 1, tag);
  endtask

  task automatic t_midline();
    ratio_in = 11'd200;
    wait_fall(); wait_fall();
    repeat (50) @(negedge clk);
    ratio_in = 11'd100;
    begin
      int per, hi, pr, pm, se, fp;
      measure(per, hi, pr, pm, se, fp);
      check(per == 150, "R5 line in progress keeps old ratio", per, 150);
    end
    line_ok(100, 1, "R5 next line");
  endtask

  task automatic t_halve();
    ratio_in = 11'd64;
    halve_en = 1'b1;
    wait_fall(); wait_fall();
    line_ok(64, 2, "R7 halved");
    ratio_in = 11'd5;
    wait_fall();
    line_ok(32, 2, "R7 halved clamp R6");
    halve_en = 1'b0;
    wait_fall();
    line_ok(32, 1, "R7 halving off");
  endtask

  initial begin
    t_reset();
    wait_fall();
    line_ok(1000, 1, "R2 nominal");
    t_ratio(40, 40, "R2 small");
    t_ratio(32, 32, "R6 floor");
    t_ratio(5, 32, "R6 clamp 5");
    t_ratio(0, 32, "R6 clamp 0");
    t_ratio(33, 33, "R6 just above");
    t_midline();
    t_halve();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule